// File: doc/BRIEF.md
# Router-to-Core Flit Bridge

This block connects an on-chip network router to a processor core. Flits arrive from the router and wait in a 16-entry queue. A dispatcher then takes them one per cycle in arrival order. A head flit opens a packet and names the target memory and the write address. The payload flits that follow are collected into one wide word. Once the last slice is in place, that word is written to the data memory or to the instruction memory. Data packets carry 64 payload bits and instruction packets carry 96.

The data-memory write port is shared with the core's own register-file stores, and a core store always wins the port. While a finished network packet waits for the port, the dispatcher stops taking flits. The queue then fills up and the router is held back through the ready signal.

Command flits control the core directly. One command loads a program start address, raises the run enable and pulses a new-PC strobe. Another stops the core. Two more set and clear a core-wide sleep signal. Sleep is only entered once no network traffic is left in the block.

Top module: `flit_core_bridge`

## Requirements
- R1: `rx_ready` is high exactly when fewer than 16 flits are held. A flit is taken only on a clock edge where `rx_valid` and `rx_ready` are both high. Flits are handled strictly in arrival order.
- R2: After synchronous reset, `rx_ready` is 1 and `dm_we`, `im_we`, `run_en`, `new_pc` and `core_sleep` are all 0.
- R3: A flit is laid out as follows: bit 37 is the lane (0 = data memory, 1 = instruction memory), bits 36:35 are the type (00 payload, 01 head, 10 command, 11 ignored), bits 34:32 are the command code and bits 31:0 are the payload. A head flit opens a packet, and its lane and payload (the write address) apply to the whole packet. A head flit that arrives inside a packet restarts it.
- R4: A data-lane packet takes two payload flits. The first fills bits 31:0 of `dm_wdata` and the second fills bits 63:32. The write (`dm_we`, `dm_addr`, `dm_wdata`) appears at the first clock edge after the packet completes at which `st_valid` is low.
- R5: When `st_valid` is high at a clock edge, the next cycle shows `dm_we`=1 with `st_addr` and `st_data`. A completed network data packet waits for the port, and while it waits no flit leaves the queue.
- R6: An instruction-lane packet takes three payload flits. Payload flit k fills bits 32k+31:32k of `im_wdata`. `im_we` is high for one cycle, in the cycle after the last flit is taken.
- R7: A payload flit taken outside an open packet is discarded and causes no memory write.
- R8: Command code 100 loads `start_pc` from the payload, sets `run_en` and pulses `new_pc` for one cycle. Command code 011 clears `run_en`.
- R9: Command code 010 requests sleep. `core_sleep` rises only at an edge where the queue is empty, no packet is open and no data write is pending.
- R10: Command code 001 clears `core_sleep` in the cycle after it is taken and cancels any sleep request still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Router offers a flit |
| rx_flit | input | 38 | Flit from the router |
| rx_ready | output | 1 | Queue has room |
| st_valid | input | 1 | Core register-file store request |
| st_addr | input | 32 | Core store address |
| st_data | input | 64 | Core store data |
| dm_we | output | 1 | Data-memory write strobe |
| dm_addr | output | 32 | Data-memory write address |
| dm_wdata | output | 64 | Data-memory write data |
| im_we | output | 1 | Instruction-memory write strobe |
| im_addr | output | 32 | Instruction-memory write address |
| im_wdata | output | 96 | Instruction-memory write data |
| run_en | output | 1 | Core run enable |
| start_pc | output | 32 | Program start address |
| new_pc | output | 1 | One-cycle strobe that loads `start_pc` |
| core_sleep | output | 1 | Puts the whole core to sleep |

## Verification
Some properties are checked on every cycle. The queue never exceeds its depth or grows while it refuses flits. A core store is always forwarded to the data port on the next cycle. Instruction writes are isolated single-cycle pulses. A new-PC strobe never appears without run enable. Sleep rises only after an empty queue.

The bench covers what single-cycle properties cannot. It checks that packet slices end up in the right bit positions. It checks that a network data write comes out after a long burst of stores. It also checks that stray payload flits are dropped, and it checks the exact cycle at which sleep is entered and left. A behavioural reference model compares every output on every clock.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int FLIT_W = 38;
  localparam int PAY_W  = 32;

  typedef enum logic [1:0] {
    FT_PAY  = 2'b00,
    FT_HEAD = 2'b01,
    FT_CMD  = 2'b10,
    FT_RSVD = 2'b11
  } ftype_e;

  localparam logic [2:0] CMD_WAKE  = 3'd1;
  localparam logic [2:0] CMD_SLEEP = 3'd2;
  localparam logic [2:0] CMD_STOP  = 3'd3;
  localparam logic [2:0] CMD_START = 3'd4;

  typedef struct packed {
    logic             lane;
    ftype_e           ftype;
    logic [2:0]       code;
    logic [PAY_W-1:0] pay;
  } flit_t;
endpackage

// File: rtl/fcb_fifo.sv
module fcb_fifo #(
  parameter int W     = 38,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/fcb_dispatch.sv
module fcb_dispatch
  import fcb_pkg::*;
#(
  parameter int DATA_BEATS  = 2,
  parameter int INSTR_BEATS = 3,
  localparam int DW = DATA_BEATS * PAY_W,
  localparam int IW = INSTR_BEATS * PAY_W,
  localparam int BW = $clog2(INSTR_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  flit_t            flit,
  input  logic             q_empty,
  input  logic             pend_take,
  output logic             pend_v,
  output logic [PAY_W-1:0] pend_addr,
  output logic [DW-1:0]    pend_data,
  output logic             im_we,
  output logic [PAY_W-1:0] im_addr,
  output logic [IW-1:0]    im_wdata,
  output logic             run_en,
  output logic [PAY_W-1:0] start_pc,
  output logic             new_pc,
  output logic             core_sleep
);
  logic             in_pkt, lane_q, slp_req;
  logic [PAY_W-1:0] addr_q;
  logic [BW-1:0]    beat_q;
  logic [IW-1:0]    buf_q, nbuf;
  logic             last_beat;

  always_comb begin
    nbuf = buf_q;
    nbuf[beat_q*PAY_W +: PAY_W] = flit.pay;
    last_beat = lane_q ? (beat_q == BW'(INSTR_BEATS - 1))
                       : (beat_q == BW'(DATA_BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0; lane_q <= 1'b0; slp_req <= 1'b0;
      addr_q <= '0; beat_q <= '0; buf_q <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_data <= '0;
      im_we <= 1'b0; im_addr <= '0; im_wdata <= '0;
      run_en <= 1'b0; start_pc <= '0; new_pc <= 1'b0;
      core_sleep <= 1'b0;
    end else begin
      new_pc <= 1'b0;
      im_we  <= 1'b0;
      if (pend_take) pend_v <= 1'b0;
      if (slp_req && q_empty && !in_pkt && !pend_v) begin
        core_sleep <= 1'b1;
        slp_req    <= 1'b0;
      end
      if (take) begin
        case (flit.ftype)
          FT_HEAD: begin
            in_pkt <= 1'b1;
            lane_q <= flit.lane;
            addr_q <= flit.pay;
            beat_q <= '0;
          end
          FT_PAY: if (in_pkt) begin
            buf_q  <= nbuf;
            beat_q <= beat_q + BW'(1);
            if (last_beat) begin
              in_pkt <= 1'b0;
              if (lane_q) begin
                im_we    <= 1'b1;
                im_addr  <= addr_q;
                im_wdata <= nbuf;
              end else begin
                pend_v    <= 1'b1;
                pend_addr <= addr_q;
                pend_data <= nbuf[DW-1:0];
              end
            end
          end
          FT_CMD: begin
            case (flit.code)
              CMD_WAKE:  begin core_sleep <= 1'b0; slp_req <= 1'b0; end
              CMD_SLEEP: slp_req <= 1'b1;
              CMD_STOP:  run_en <= 1'b0;
              CMD_START: begin
                run_en   <= 1'b1;
                start_pc <= flit.pay;
                new_pc   <= 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcb_dm_arb.sv
module fcb_dm_arb #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          pend_v,
  input  logic [AW-1:0] pend_addr,
  input  logic [DW-1:0] pend_data,
  output logic          pend_take,
  output logic          dm_we,
  output logic [AW-1:0] dm_addr,
  output logic [DW-1:0] dm_wdata
);
  assign pend_take = pend_v && !st_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_we    <= 1'b0;
      dm_addr  <= '0;
      dm_wdata <= '0;
    end else begin
      dm_we <= st_valid || pend_v;
      if (st_valid) begin
        dm_addr  <= st_addr;
        dm_wdata <= st_data;
      end else if (pend_v) begin
        dm_addr  <= pend_addr;
        dm_wdata <= pend_data;
      end
    end
  end
endmodule

// File: rtl/flit_core_bridge.sv
module flit_core_bridge
  import fcb_pkg::*;
#(
  parameter int QDEPTH      = 16,
  parameter int DATA_BEATS  = 2,
  parameter int INSTR_BEATS = 3,
  localparam int DW = DATA_BEATS * PAY_W,
  localparam int IW = INSTR_BEATS * PAY_W,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              rx_ready,
  input  logic              st_valid,
  input  logic [PAY_W-1:0]  st_addr,
  input  logic [DW-1:0]     st_data,
  output logic              dm_we,
  output logic [PAY_W-1:0]  dm_addr,
  output logic [DW-1:0]     dm_wdata,
  output logic              im_we,
  output logic [PAY_W-1:0]  im_addr,
  output logic [IW-1:0]     im_wdata,
  output logic              run_en,
  output logic [PAY_W-1:0]  start_pc,
  output logic              new_pc,
  output logic              core_sleep
);
  logic [FLIT_W-1:0] q_dout;
  logic [CW-1:0]     q_count;
  logic              q_full, q_empty, q_push, q_pop;
  logic              pend_v, pend_take;
  logic [PAY_W-1:0]  pend_addr;
  logic [DW-1:0]     pend_data;

  assign rx_ready = !q_full;
  assign q_push   = rx_valid && !q_full;
  assign q_pop    = !q_empty && !pend_v;

  fcb_fifo #(.W(FLIT_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .din(rx_flit), .pop(q_pop),
    .dout(q_dout), .count(q_count), .full(q_full), .empty(q_empty)
  );

  fcb_dispatch #(.DATA_BEATS(DATA_BEATS), .INSTR_BEATS(INSTR_BEATS)) u_disp (
    .clk(clk), .rst(rst), .take(q_pop), .flit(flit_t'(q_dout)),
    .q_empty(q_empty), .pend_take(pend_take), .pend_v(pend_v),
    .pend_addr(pend_addr), .pend_data(pend_data), .im_we(im_we),
    .im_addr(im_addr), .im_wdata(im_wdata), .run_en(run_en),
    .start_pc(start_pc), .new_pc(new_pc), .core_sleep(core_sleep)
  );

  fcb_dm_arb #(.AW(PAY_W), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .pend_v(pend_v), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_take(pend_take), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );
endmodule

// File: rtl/fcb_checker.sv
module fcb_checker #(
  parameter int QDEPTH = 16,
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_ready,
  input logic          st_valid,
  input logic [AW-1:0] st_addr,
  input logic [DW-1:0] st_data,
  input logic          dm_we,
  input logic [AW-1:0] dm_addr,
  input logic [DW-1:0] dm_wdata,
  input logic          im_we,
  input logic          new_pc,
  input logic          run_en,
  input logic          core_sleep,
  input logic [CW-1:0] q_count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(QDEPTH)); // R1
  AST_NO_GROW_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |=> q_count <= $past(q_count)); // R1
  AST_STORE_WINS: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> dm_we && dm_addr == $past(st_addr) && dm_wdata == $past(st_data)); // R5
  AST_IM_PULSE: assert property (@(posedge clk) disable iff (rst)
    im_we |=> !im_we); // R6
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    new_pc |-> run_en); // R8
  AST_SLEEP_DRAINED: assert property (@(posedge clk) disable iff (rst)
    $rose(core_sleep) |-> $past(q_count) == '0); // R9
endmodule

bind flit_core_bridge fcb_checker #(
  .QDEPTH(QDEPTH), .AW(fcb_pkg::PAY_W), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .st_valid(st_valid),
  .st_addr(st_addr), .st_data(st_data), .dm_we(dm_we), .dm_addr(dm_addr),
  .dm_wdata(dm_wdata), .im_we(im_we), .new_pc(new_pc), .run_en(run_en),
  .core_sleep(core_sleep), .q_count(q_count)
);

// File: tb/flit_core_bridge_test.sv
module flit_core_bridge_test;
  import fcb_pkg::*;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, rx_valid, rx_ready, st_valid, dm_we, im_we, run_en, new_pc, core_sleep;
  logic [37:0] rx_flit;
  logic [31:0] st_addr, dm_addr, im_addr, start_pc;
  logic [63:0] st_data, dm_wdata;
  logic [95:0] im_wdata;

  flit_core_bridge uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_flit(rx_flit), .rx_ready(rx_ready),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .im_we(im_we), .im_addr(im_addr),
    .im_wdata(im_wdata), .run_en(run_en), .start_pc(start_pc), .new_pc(new_pc),
    .core_sleep(core_sleep)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  flit_t mq[$];
  flit_t f;
  bit m_inpkt, m_lane, m_pend, m_slpreq, m_sleep, m_run, m_npc, m_imwe, m_dmwe, m_dmsrc;
  bit o_pend, o_inpkt;
  int o_size, m_beat;
  logic [31:0] m_addr, m_paddr, m_dmaddr, m_imaddr, m_pc;
  logic [95:0] m_buf, m_imdata;
  logic [63:0] m_pdata, m_dmdata;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_inpkt = 0; m_lane = 0; m_pend = 0; m_slpreq = 0; m_sleep = 0;
      m_run = 0; m_npc = 0; m_imwe = 0; m_dmwe = 0; m_dmsrc = 0; m_beat = 0;
    end else begin
      o_pend = m_pend; o_size = mq.size(); o_inpkt = m_inpkt;
      m_npc = 0; m_imwe = 0;
      if (st_valid) begin
        m_dmwe = 1; m_dmaddr = st_addr; m_dmdata = st_data; m_dmsrc = 1;
      end else if (o_pend) begin
        m_dmwe = 1; m_dmaddr = m_paddr; m_dmdata = m_pdata; m_pend = 0; m_dmsrc = 0;
      end else m_dmwe = 0;
      if (m_slpreq && o_size == 0 && !o_inpkt && !o_pend) begin
        m_sleep = 1; m_slpreq = 0;
      end
      if (o_size > 0 && !o_pend) begin
        f = mq.pop_front();
        case (f.ftype)
          FT_HEAD: begin m_inpkt = 1; m_lane = f.lane; m_addr = f.pay; m_beat = 0; end
          FT_PAY: if (m_inpkt) begin
            m_buf[m_beat*32 +: 32] = f.pay;
            m_beat++;
            if (m_beat == (m_lane ? 3 : 2)) begin
              m_inpkt = 0;
              if (m_lane) begin m_imwe = 1; m_imaddr = m_addr; m_imdata = m_buf; end
              else begin m_pend = 1; m_paddr = m_addr; m_pdata = m_buf[63:0]; end
            end
          end
          FT_CMD: case (f.code)
            3'd1: begin m_sleep = 0; m_slpreq = 0; end
            3'd2: m_slpreq = 1;
            3'd3: m_run = 0;
            3'd4: begin m_run = 1; m_pc = f.pay; m_npc = 1; end
            default: ;
          endcase
          default: ;
        endcase
      end
      if (rx_valid && o_size < DEPTH) mq.push_back(flit_t'(rx_flit));
    end
  end

  // per-cycle comparison and monitors
  bit saw_full;
  int n_writes;
  logic [31:0] last_dm_addr, last_im_addr;
  logic [63:0] last_dm_data;
  logic [95:0] last_im_data;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "rx_ready", rx_ready, mq.size() < DEPTH);
      chk(m_dmsrc ? "R5" : "R4", "dm_we", dm_we, m_dmwe);
      if (m_dmwe) begin
        chk(m_dmsrc ? "R5" : "R4", "dm_addr", dm_addr, m_dmaddr);
        chk(m_dmsrc ? "R5" : "R4", "dm_wdata", dm_wdata, m_dmdata);
      end
      chk("R6", "im_we", im_we, m_imwe);
      if (m_imwe) begin
        chk("R6", "im_addr", im_addr, m_imaddr);
        chk("R6", "im_wdata", im_wdata, m_imdata);
      end
      chk("R8", "run_en", run_en, m_run);
      chk("R8", "new_pc", new_pc, m_npc);
      if (m_run) chk("R8", "start_pc", start_pc, m_pc);
      chk("R9", "core_sleep", core_sleep, m_sleep);
      if (!rx_ready) saw_full = 1;
      if (dm_we || im_we) n_writes++;
      if (dm_we) begin last_dm_addr = dm_addr; last_dm_data = dm_wdata; end
      if (im_we) begin last_im_addr = im_addr; last_im_data = im_wdata; end
    end
  end

  function automatic logic [37:0] mk(bit lane, logic [1:0] ft, logic [2:0] code, logic [31:0] p);
    return {lane, ft, code, p};
  endfunction

  task automatic send(logic [37:0] fl);
    bit acc;
    rx_valid = 1; rx_flit = fl;
    do begin
      acc = rx_ready;
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic idle(int n);
    rx_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst = 1; rx_valid = 0; rx_flit = '0; st_valid = 0; st_addr = '0; st_data = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    chk("R2", "rx_ready", rx_ready, 1);
    chk("R2", "dm_we", dm_we, 0);
    chk("R2", "im_we", im_we, 0);
    chk("R2", "run_en", run_en, 0);
    chk("R2", "new_pc", new_pc, 0);
    chk("R2", "core_sleep", core_sleep, 0);

    // R4 data packet
    send(mk(0, 2'b01, 0, 32'h100));
    send(mk(1, 2'b00, 0, 32'hAAAA0001));
    send(mk(0, 2'b00, 0, 32'hBBBB0002));
    idle(6);
    chk("R4", "data addr", last_dm_addr, 32'h100);
    chk("R4", "data word", last_dm_data, 64'hBBBB0002_AAAA0001);

    // R3 / R6 instruction packet, with a restarted head first
    send(mk(1, 2'b01, 0, 32'h7777));
    send(mk(0, 2'b00, 0, 32'h0));
    send(mk(1, 2'b01, 0, 32'h200));
    send(mk(0, 2'b00, 0, 32'h11));
    send(mk(0, 2'b00, 0, 32'h22));
    send(mk(0, 2'b00, 0, 32'h33));
    idle(6);
    chk("R3", "instr addr", last_im_addr, 32'h200);
    chk("R6", "instr word", last_im_data, 96'h33_00000022_00000011);

    // R8 start then stop
    send(mk(0, 2'b10, 3'd4, 32'h4000));
    idle(3);
    chk("R8", "start_pc", start_pc, 32'h4000);
    chk("R8", "run_en set", run_en, 1);
    send(mk(0, 2'b10, 3'd3, 32'h0));
    idle(3);
    chk("R8", "run_en cleared", run_en, 0);

    // R7 orphan payload
    n_writes = 0;
    send(mk(0, 2'b00, 0, 32'hDEAD));
    send(mk(1, 2'b11, 0, 32'hBEEF));
    idle(6);
    chk("R7", "writes after orphan", n_writes, 0);

    // R5 store priority with the queue backing up (R1)
    saw_full = 0;
    fork
      begin
        st_valid = 1;
        for (int i = 0; i < 40; i++) begin
          st_addr = 32'h9000 + i; st_data = {2{32'(i)}};
          @(negedge clk);
        end
        st_valid = 0;
      end
      begin
        send(mk(0, 2'b01, 0, 32'h300));
        send(mk(0, 2'b00, 0, 32'h5));
        send(mk(0, 2'b00, 0, 32'h6));
        for (int i = 0; i < 20; i++) send(mk(0, 2'b10, 3'd0, 32'(i)));
        rx_valid = 0;
      end
    join
    idle(30);
    chk("R1", "queue filled and blocked", saw_full, 1);
    chk("R5", "deferred network write", last_dm_addr, 32'h300);
    chk("R5", "deferred network data", last_dm_data, 64'h6_00000005);

    // R9 sleep held off while traffic remains, R10 wake
    send(mk(0, 2'b10, 3'd2, 32'h0));
    send(mk(0, 2'b00, 0, 32'h1));
    send(mk(0, 2'b00, 0, 32'h2));
    send(mk(0, 2'b00, 0, 32'h3));
    rx_valid = 0;
    chk("R9", "no sleep while busy", core_sleep, 0);
    idle(5);
    chk("R9", "sleep after drain", core_sleep, 1);
    send(mk(0, 2'b10, 3'd1, 32'h0));
    rx_valid = 0;
    @(negedge clk);
    chk("R10", "wake next cycle", core_sleep, 0);
    idle(4);
    chk("R10", "stays awake", core_sleep, 0);
    summary();
  end
endmodule